// File: doc/BRIEF.md
# Coarse Delay Calibration Sweep Controller

This block searches for the coarse delay setting that places the quadrature injection phases of an injection-locked oscillator on the oscillator zero crossing. It works through two delay lines in sequence. For every candidate code of the first line it drives a small square-wave test pattern into the phase-rotator control word. The pattern is normalised by a running gain estimate. It then adapts that estimate by a sign-correlated LMS update fed by the PLL phase error. The code whose converged estimate is largest is kept. The second line is then swept the same way while the first stays on its chosen code.

The converged code and gain of each line are kept in result registers for normal operation. While idle, the first line's applied code is trimmed by a linear temperature-drift model. The PLL, the rotator and the analog delay lines themselves are outside this block.

Top module: `dlycal_sweep`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high until the last code of the second line is evaluated. A `start` while busy has no effect on the sweep or its results.
- R2: During the first search, `dly1_code` steps through codes 0 up to 2^CODE_W-1 in ascending order and `dly2_code` is parked at 2^(CODE_W-1). During the second search, `dly1_code` holds the code chosen for line 1 (untrimmed) and `dly2_code` steps through 0 up to 2^CODE_W-1.
- R3: The test-pattern sign is positive for the first `half_per` accepted updates of each code. It then inverts after every further `half_per` accepted updates, and restarts positive when the next code begins.
- R4: While busy, `test_word` equals plus or minus floor(`test_amp`*`fr_scale`/K), with the sign of R3 and K the current gain estimate. While idle it is 0.
- R5: On every accepted update, K becomes K + ((s*`phe`) >>> `mu_shift`), where s is +1 or -1 per R3, saturated to the range [1, 2^K_W-1]. K restarts from `k_init` at each code, and a `k_init` of 0 is taken as 1.
- R6: A cycle with `phe_valid` low makes no update: K, the pattern sign, the update count and the delay codes are unchanged, and `phe` is ignored.
- R7: After `hold_len` accepted updates the code's K is captured. Across one line, the code with the largest captured K is chosen, and on equal K the lower code wins.
- R8: The chosen code and its K for each line appear on `res_code1`/`res_gain1` and `res_code2`/`res_gain2`. They are held until the next search overwrites them.
- R9: `done` is a one-cycle pulse in the cycle in which `busy` first reads low after a sweep.
- R10: While idle, `dly1_code` = `res_code1` + ((`temp_delta`*`drift_slope`) >>> 4), clamped to [0, 2^CODE_W-1], and `dly2_code` = `res_code2`.
- R11: After reset `busy` and `done` are low, `test_word` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a two-line search |
| phe_valid | input | 1 | Phase-error sample is valid this cycle |
| phe | input | PHE_W | Signed PLL phase error |
| k_init | input | K_W | Starting gain estimate for each code |
| mu_shift | input | MU_W | LMS step as a right shift |
| hold_len | input | HOLD_W | Accepted updates per code (at least 1) |
| half_per | input | HP_W | Updates per test-pattern half period (at least 1) |
| test_amp | input | AMP_W | Test-pattern amplitude |
| fr_scale | input | FR_W | Reference-frequency scale numerator |
| temp_delta | input | TEMP_W | Signed temperature offset from calibration |
| drift_slope | input | TEMP_W | Signed delay-drift coefficient |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| dly1_code | output | CODE_W | Applied code of delay line 1 |
| dly2_code | output | CODE_W | Applied code of delay line 2 |
| test_word | output | AMP_W+FR_W+1 | Signed rotator control-word deviation |
| res_code1 | output | CODE_W | Stored chosen code, line 1 |
| res_gain1 | output | K_W | Stored gain of that code, line 1 |
| res_code2 | output | CODE_W | Stored chosen code, line 2 |
| res_gain2 | output | K_W | Stored gain of that code, line 2 |

## Verification
The assertions assume that `hold_len` and `half_per` are at least 1 and that every configuration input stays steady while `busy` is high, because counters compare against these values in flight. The bench sets the configuration only while the block is idle and never uses a zero length. It drives phase error as plus or minus a per-code magnitude that follows its own model of the pattern sign, so every gain the block should capture is known in closed form. The bench inserts invalid cycles carrying junk phase error and a stray `start` inside the sweep, and checks every test word against the model.

// File: rtl/dlycal_pkg.sv
// Package: shared types for the delay calibration sweep.
// Assumes nothing beyond IEEE 1800-2017.
package dlycal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LINE1 = 2'd1,
        ST_LINE2 = 2'd2
    } cal_state_t;
endpackage

// File: rtl/dlycal_sqwave.sv
// Square-wave test-pattern sign generator.
// Toggles the sign every half_per accepted steps; clear restarts it positive.
// Assumes half_per >= 1 and stable while stepping.
module dlycal_sqwave #(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic [HP_W-1:0] half_per,
    output logic            neg
);
    logic [HP_W-1:0] cnt;

    // Count accepted steps and flip the sign at each half-period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            neg <= 1'b0;
        end else if (clear) begin
            cnt <= '0;
            neg <= 1'b0;
        end else if (step) begin
            if (cnt == half_per - 1'b1) begin
                cnt <= '0;
                neg <= ~neg;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(neg)); // R3
endmodule

// File: rtl/dlycal_lms.sv
// Sign-correlated LMS gain estimator.
// k_next = sat(k + ((+/-phe) >>> mu)) to [1, 2^K_W-1]; load restarts k.
// Assumes load and step are never high together in a useful way (load wins).
module dlycal_lms #(
    parameter int PHE_W = 12,
    parameter int K_W   = 16,
    parameter int MU_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [K_W-1:0]          load_val,
    input  logic                    step,
    input  logic                    neg,
    input  logic signed [PHE_W-1:0] phe,
    input  logic [MU_W-1:0]         mu,
    output logic [K_W-1:0]          k,
    output logic [K_W-1:0]          k_next
);
    localparam int SUM_W = ((K_W > PHE_W) ? K_W : PHE_W) + 2;
    localparam logic signed [SUM_W-1:0] K_MAX = {{(SUM_W-K_W){1'b0}}, {K_W{1'b1}}};
    localparam logic signed [SUM_W-1:0] K_MIN = {{(SUM_W-1){1'b0}}, 1'b1};

    logic signed [PHE_W:0]   phe_x;
    logic signed [PHE_W:0]   corr;
    logic signed [PHE_W:0]   delta;
    logic signed [SUM_W-1:0] sum;

    // Correlate the phase error with the pattern sign, scale, add and saturate.
    always_comb begin
        phe_x = {phe[PHE_W-1], phe};
        corr  = neg ? -phe_x : phe_x;
        delta = corr >>> mu;
        sum   = $signed({{(SUM_W-K_W){1'b0}}, k}) +
                $signed({{(SUM_W-PHE_W-1){delta[PHE_W]}}, delta});
        if (sum < K_MIN)      k_next = {{(K_W-1){1'b0}}, 1'b1};
        else if (sum > K_MAX) k_next = {K_W{1'b1}};
        else                  k_next = sum[K_W-1:0];
    end

    // Hold the estimate; restart it on load, advance it on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            k <= {{(K_W-1){1'b0}}, 1'b1};
        else if (load)
            k <= (load_val == '0) ? {{(K_W-1){1'b0}}, 1'b1} : load_val;
        else if (step)
            k <= k_next;
    end

    AST_GAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        k != '0); // R5
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(k)); // R6
endmodule

// File: rtl/dlycal_scale.sv
// Gain-normalised test word: +/- floor(amp*fr / k).
// Assumes k is never zero (guaranteed by the estimator).
module dlycal_scale #(
    parameter int AMP_W = 8,
    parameter int FR_W  = 8,
    parameter int K_W   = 16,
    localparam int PROD_W = AMP_W + FR_W,
    localparam int TW_W   = PROD_W + 1
) (
    input  logic [AMP_W-1:0]       amp,
    input  logic [FR_W-1:0]        fr,
    input  logic [K_W-1:0]         k,
    input  logic                   neg,
    output logic signed [TW_W-1:0] tw
);
    localparam int DIV_W = (PROD_W > K_W) ? PROD_W : K_W;

    logic [PROD_W-1:0] prod;
    logic [DIV_W-1:0]  num;
    logic [DIV_W-1:0]  den;
    logic [DIV_W-1:0]  quo;
    logic [PROD_W-1:0] mag;

    // Scale the amplitude by fr over the gain estimate and apply the sign.
    always_comb begin
        prod = PROD_W'(amp) * PROD_W'(fr);
        num  = DIV_W'(prod);
        den  = DIV_W'(k);
        quo  = num / den;
        mag  = quo[PROD_W-1:0];
        tw   = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/dlycal_sweep.sv
// Top: nested two-line coarse delay search maximising the LMS gain estimate.
// Line 1 is swept with line 2 parked mid-range; line 2 is then swept with
// line 1 on its chosen code. Assumes hold_len >= 1, half_per >= 1 and all
// configuration inputs steady while busy.
module dlycal_sweep
    import dlycal_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int PHE_W   = 12,
    parameter int K_W     = 16,
    parameter int MU_W    = 3,
    parameter int HOLD_W  = 10,
    parameter int HP_W    = 8,
    parameter int AMP_W   = 8,
    parameter int FR_W    = 8,
    parameter int TEMP_W  = 8,
    parameter int TEMP_SH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          phe_valid,
    input  logic signed [PHE_W-1:0]       phe,
    input  logic [K_W-1:0]                k_init,
    input  logic [MU_W-1:0]               mu_shift,
    input  logic [HOLD_W-1:0]             hold_len,
    input  logic [HP_W-1:0]               half_per,
    input  logic [AMP_W-1:0]              test_amp,
    input  logic [FR_W-1:0]               fr_scale,
    input  logic signed [TEMP_W-1:0]      temp_delta,
    input  logic signed [TEMP_W-1:0]      drift_slope,
    output logic                          busy,
    output logic                          done,
    output logic [CODE_W-1:0]             dly1_code,
    output logic [CODE_W-1:0]             dly2_code,
    output logic signed [AMP_W+FR_W:0]    test_word,
    output logic [CODE_W-1:0]             res_code1,
    output logic [K_W-1:0]                res_gain1,
    output logic [CODE_W-1:0]             res_code2,
    output logic [K_W-1:0]                res_gain2
);
    localparam int TW_W = AMP_W + FR_W + 1;
    localparam int TP_W = 2 * TEMP_W;
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] D2_PARK  = CODE_W'(1) << (CODE_W - 1);

    cal_state_t          state;
    logic [CODE_W-1:0]   cur_code;
    logic [HOLD_W-1:0]   upd_cnt;
    logic [CODE_W-1:0]   best_code;
    logic [K_W-1:0]      best_k;
    logic                launch;
    logic                seg_end;
    logic                upd;
    logic                neg;
    logic [K_W-1:0]      k_cur;
    logic [K_W-1:0]      k_next;
    logic                take_new;
    logic [CODE_W-1:0]   cand_code;
    logic [K_W-1:0]      cand_k;
    logic signed [TW_W-1:0] tw_raw;
    logic signed [TP_W-1:0] t_prod;
    logic signed [TP_W-1:0] t_corr;
    logic signed [TP_W:0]   t_sum;
    logic [CODE_W-1:0]   dly1_trim;

    // Decode sweep control strobes from the state and update counter.
    always_comb begin
        launch  = (state == ST_IDLE) && start;
        upd     = busy && phe_valid;
        seg_end = upd && (upd_cnt == hold_len - 1'b1);
    end

    assign busy = (state != ST_IDLE);

    dlycal_sqwave #(.HP_W(HP_W)) u_sq (
        .clk(clk), .rst_n(rst_n), .clear(launch | seg_end), .step(upd),
        .half_per(half_per), .neg(neg)
    );

    dlycal_lms #(.PHE_W(PHE_W), .K_W(K_W), .MU_W(MU_W)) u_lms (
        .clk(clk), .rst_n(rst_n), .load(launch | seg_end), .load_val(k_init),
        .step(upd), .neg(neg), .phe(phe), .mu(mu_shift),
        .k(k_cur), .k_next(k_next)
    );

    dlycal_scale #(.AMP_W(AMP_W), .FR_W(FR_W), .K_W(K_W)) u_scale (
        .amp(test_amp), .fr(fr_scale), .k(k_cur), .neg(neg), .tw(tw_raw)
    );

    // Pick the candidate best: strictly larger gain replaces, ties keep the lower code.
    always_comb begin
        take_new  = (k_next > best_k);
        cand_code = take_new ? cur_code : best_code;
        cand_k    = take_new ? k_next : best_k;
    end

    // Sweep sequencer: code stepping, best tracking, result capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_code  <= '0;
            upd_cnt   <= '0;
            best_code <= '0;
            best_k    <= '0;
            res_code1 <= '0;
            res_gain1 <= '0;
            res_code2 <= '0;
            res_gain2 <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                state     <= ST_LINE1;
                cur_code  <= '0;
                upd_cnt   <= '0;
                best_code <= '0;
                best_k    <= '0;
            end else if (seg_end) begin
                upd_cnt <= '0;
                if (cur_code == CODE_MAX) begin
                    cur_code  <= '0;
                    best_code <= '0;
                    best_k    <= '0;
                    if (state == ST_LINE1) begin
                        res_code1 <= cand_code;
                        res_gain1 <= cand_k;
                        state     <= ST_LINE2;
                    end else begin
                        res_code2 <= cand_code;
                        res_gain2 <= cand_k;
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                    end
                end else begin
                    cur_code  <= cur_code + 1'b1;
                    best_code <= cand_code;
                    best_k    <= cand_k;
                end
            end else if (upd) begin
                upd_cnt <= upd_cnt + 1'b1;
            end
        end
    end

    // Temperature trim of the stored line-1 code, clamped to the code range.
    always_comb begin
        t_prod = TP_W'(temp_delta) * TP_W'(drift_slope);
        t_corr = t_prod >>> TEMP_SH;
        t_sum  = $signed({1'b0, {(TP_W-CODE_W){1'b0}}, res_code1}) +
                 $signed({t_corr[TP_W-1], t_corr});
        if (t_sum < 0)
            dly1_trim = '0;
        else if (t_sum > $signed({1'b0, {(TP_W-CODE_W){1'b0}}, CODE_MAX}))
            dly1_trim = CODE_MAX;
        else
            dly1_trim = t_sum[CODE_W-1:0];
    end

    // Route the delay codes and gate the test word by the sweep phase.
    always_comb begin
        unique case (state)
            ST_LINE1: begin dly1_code = cur_code;  dly2_code = D2_PARK;   end
            ST_LINE2: begin dly1_code = res_code1; dly2_code = cur_code;  end
            default:  begin dly1_code = dly1_trim; dly2_code = res_code2; end
        endcase
        test_word = busy ? tw_raw : '0;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R9
    AST_NO_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !phe_valid) |=> ($stable(upd_cnt) && $stable(cur_code))); // R6
    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_code1) && $stable(res_gain2))); // R8
endmodule

// File: tb/dlycal_sweep_bench.sv
// Bench: full two-line sweeps with a closed-form gain model per code.
module dlycal_sweep_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic phe_valid = 1'b0;
    logic signed [11:0] phe = '0;
    logic [15:0] k_init = 16'd64;
    logic [2:0]  mu_shift = 3'd1;
    logic [9:0]  hold_len = 10'd6;
    logic [7:0]  half_per = 8'd2;
    logic [7:0]  test_amp = 8'd10;
    logic [7:0]  fr_scale = 8'd50;
    logic signed [7:0] temp_delta = '0;
    logic signed [7:0] drift_slope = '0;
    logic busy, done;
    logic [2:0] dly1_code, dly2_code, res_code1, res_code2;
    logic signed [16:0] test_word;
    logic [15:0] res_gain1, res_gain2;

    int errors = 0;
    int checks = 0;
    int g1 [8];
    int g2 [8];

    always #10 clk = ~clk;

    dlycal_sweep u_dlycal_sweep (
        .clk(clk), .rst_n(rst_n), .start(start), .phe_valid(phe_valid), .phe(phe),
        .k_init(k_init), .mu_shift(mu_shift), .hold_len(hold_len), .half_per(half_per),
        .test_amp(test_amp), .fr_scale(fr_scale), .temp_delta(temp_delta),
        .drift_slope(drift_slope), .busy(busy), .done(done), .dly1_code(dly1_code),
        .dly2_code(dly2_code), .test_word(test_word), .res_code1(res_code1),
        .res_gain1(res_gain1), .res_code2(res_code2), .res_gain2(res_gain2)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ksat(input int k);
        if (k < 1) return 1;
        if (k > 65535) return 65535;
        return k;
    endfunction

    function automatic int exp_tw(input int k, input bit n);
        int q;
        q = (int'(test_amp) * int'(fr_scale)) / k;
        return n ? -q : q;
    endfunction

    // One full calibration; the gain tables g1/g2 set the phase-error magnitude per code.
    task automatic run_cal();
        int k, bk, bc, r1c, r1k, k0;
        bit n;
        k0 = (k_init == 0) ? 1 : int'(k_init);
        r1c = 0; r1k = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        for (int s = 0; s < 2; s++) begin
            bk = -1; bc = 0;
            for (int c = 0; c < 8; c++) begin
                if (s == 0) begin
                    chk(dly1_code == 3'(c), "R2 line1 sweep code", int'(dly1_code), c);
                    chk(dly2_code == 3'd4, "R2 line2 parked", int'(dly2_code), 4);
                end else begin
                    chk(dly1_code == 3'(r1c), "R2 line1 held", int'(dly1_code), r1c);
                    chk(dly2_code == 3'(c), "R2 line2 sweep code", int'(dly2_code), c);
                end
                k = k0;
                for (int j = 0; j < int'(hold_len); j++) begin
                    int gv;
                    n = ((j / int'(half_per)) % 2) == 1;
                    chk(int'(test_word) == exp_tw(k, n), "R3 R4 R5 test word",
                        int'(test_word), exp_tw(k, n));
                    chk(busy == 1'b1, "R1 busy in sweep", int'(busy), 1);
                    gv = (s == 0) ? g1[c] : g2[c];
                    if (j == 1) begin
                        phe_valid = 1'b0;
                        phe = 12'sh5A5;
                        if (s == 1 && c == 2) start = 1'b1;
                        @(negedge clk);
                        start = 1'b0;
                        chk(int'(test_word) == exp_tw(k, n), "R6 invalid cycle ignored",
                            int'(test_word), exp_tw(k, n));
                    end
                    phe_valid = 1'b1;
                    phe = 12'(n ? -gv : gv);
                    @(negedge clk);
                    phe_valid = 1'b0;
                    phe = '0;
                    k = ksat(k + (gv >>> int'(mu_shift)));
                end
                if (k > bk) begin bk = k; bc = c; end
            end
            if (s == 0) begin
                r1c = bc; r1k = bk;
                chk(res_code1 == 3'(bc), "R7 R8 line1 code", int'(res_code1), bc);
                chk(int'(res_gain1) == bk, "R8 line1 gain", int'(res_gain1), bk);
            end else begin
                chk(done == 1'b1, "R9 done pulse", int'(done), 1);
                chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
                chk(test_word == '0, "R4 idle test word", int'(test_word), 0);
                chk(res_code2 == 3'(bc), "R7 R8 line2 code", int'(res_code2), bc);
                chk(int'(res_gain2) == bk, "R8 line2 gain", int'(res_gain2), bk);
                chk(dly2_code == 3'(bc), "R10 idle line2 code", int'(dly2_code), bc);
                @(negedge clk);
                chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
                chk(res_code1 == 3'(r1c) && int'(res_gain1) == r1k,
                    "R8 line1 results held", int'(res_code1), r1c);
            end
        end
    endtask

    task automatic chk_trim(input int td, input int sl, input int exp);
        temp_delta = 8'(td);
        drift_slope = 8'(sl);
        @(negedge clk);
        chk(dly1_code == 3'(exp), "R10 temperature trim", int'(dly1_code), exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R11 reset flags", int'(busy), 0);
        chk(test_word == '0, "R11 reset test word", int'(test_word), 0);
        chk(res_code1 == '0 && res_code2 == '0, "R11 reset codes", int'(res_code1), 0);
        chk(res_gain1 == '0 && res_gain2 == '0, "R11 reset gains", int'(res_gain1), 0);

        // Run A: tie between codes 3 and 4, floor saturation on code 7.
        g1 = '{10, 40, -30, 80, 80, 5, 0, -2000};
        g2 = '{0, 0, 0, 0, 0, 0, 0, 200};
        run_cal();
        chk(res_code1 == 3'd3, "R7 tie lower code wins", int'(res_code1), 3);
        chk(int'(res_gain1) == 304, "R5 converged gain", int'(res_gain1), 304);
        chk(res_code2 == 3'd7, "R7 line2 top code", int'(res_code2), 7);
        chk_trim(0, 0, 3);
        chk_trim(20, 8, 7);
        chk_trim(-20, 4, 0);
        chk_trim(-8, 4, 1);
        chk_trim(0, 0, 3);

        // Run B: ceiling saturation, all-equal line 2, zero shift, odd half period.
        k_init = 16'd65000; mu_shift = 3'd0; hold_len = 10'd5; half_per = 8'd3;
        test_amp = 8'd255; fr_scale = 8'd255;
        g1 = '{0, 0, 0, 0, 0, 2047, 0, 0};
        g2 = '{-1, -1, -1, -1, -1, -1, -1, -1};
        run_cal();
        chk(res_code1 == 3'd5 && res_gain1 == 16'hFFFF, "R5 ceiling saturation",
            int'(res_gain1), 65535);
        chk(res_code2 == 3'd0, "R7 all equal picks code 0", int'(res_code2), 0);

        // Run C: zero starting gain taken as 1.
        k_init = 16'd0; mu_shift = 3'd2; hold_len = 10'd4; half_per = 8'd1;
        test_amp = 8'd3; fr_scale = 8'd7;
        g1 = '{4, 8, 12, 16, 20, 24, 28, 32};
        g2 = '{32, 28, 24, 20, 16, 12, 8, 4};
        run_cal();
        chk(res_code1 == 3'd7 && res_code2 == 3'd0, "R7 monotone tables",
            int'(res_code1), 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule